// File: doc/BRIEF.md
# Soft-Decision Output Formatter

This block receives one demodulated symbol at a time, an in-phase and a quadrature soft decision plus a flag that says whether a signal is present, and shows it on an output port in one of two arrangements. Each soft decision is a 3-bit sign-magnitude word. Bit 2 is the sign, which is also the hard decision. Bits 1:0 are the confidence, running from 00 (least sure) to 11 (most sure). The block passes the words through unchanged.

In parallel arrangement, both words appear together on their own lanes for one period of the output clock, and that clock serves as the symbol clock. In serial arrangement, a single muxed lane carries one word per output-clock period, and a sync flag tells I slots from Q slots. A one-dimensional (BPSK) stream sends only I words. A two-dimensional (QPSK) stream sends I and then Q of the same symbol in two consecutive periods. The output clock is made from the system clock by a programmable divider. Output words change only where that clock falls, so they are steady at its rising edge.

Symbols enter through a valid/ready handshake into a single holding slot. A sequencer with three states controls that slot:
- ST_EMPTY: nothing is held and ready is high. An accepted symbol moves it to ST_FULL.
- ST_FULL: a symbol waits for the next output-clock fall. At that fall, parallel or BPSK-serial emission returns to ST_EMPTY, while QPSK-serial emission of the I word moves to ST_QSLOT.
- ST_QSLOT: the Q word is still owed. The next fall emits it and returns to ST_EMPTY.

The arrangement and modulation selections are read only at the fall that starts a symbol's first slot.

Top module: `sdfmt_top`

## Requirements
- R1: While reset is asserted and right after it is released, out_clk is 0, in_ready is 1, and out_i, out_q, out_mux, out_sync and out_act are all 0.
- R2: out_clk toggles every cfg_half_div+1 system-clock cycles, so one period lasts 2*(cfg_half_div+1) cycles. The output words and flags change only in the cycle in which out_clk falls.
- R3: With cfg_serial=0, each symbol occupies one out_clk period. out_i and out_q carry its I and Q words during that period, while out_mux=0 and out_sync=0.
- R4: With cfg_serial=1 and cfg_qpsk=0, each symbol occupies one out_clk period. out_mux carries its I word, out_sync=1, and out_i=out_q=0.
- R5: With cfg_serial=1 and cfg_qpsk=1, each symbol occupies two consecutive out_clk periods. The first has out_mux=I and out_sync=1; the second has out_mux=Q and out_sync=0. out_i=out_q=0 throughout.
- R6: in_ready is 1 only when no symbol is held. It drops in the cycle after an accepted transfer and rises only in the cycle where out_clk falls to start the symbol's last slot. In QPSK serial mode it therefore stays 0 while the I word is on the output.
- R7: in_act is captured with its symbol and shown on out_act during every slot of that symbol.
- R8: A slot that starts with no symbol held drives out_i, out_q, out_mux, out_sync and out_act to 0.
- R9: cfg_serial and cfg_qpsk are sampled only at the fall that starts a symbol's first slot. A change while the Q word is pending does not alter that Q slot.
- R10: The 3-bit words appear bit-exact on the output: bit 2 is the sign and bits 1:0 the confidence, for every value from 000 to 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_serial | input | 1 | 1 = serial arrangement, 0 = parallel |
| cfg_qpsk | input | 1 | 1 = I and Q slots per symbol in serial, 0 = I only |
| cfg_half_div | input | DIV_W | Output-clock half period minus one, in system cycles |
| in_valid | input | 1 | A symbol is offered |
| in_ready | output | 1 | Holding slot is free |
| in_i | input | 3 | I soft decision, sign-magnitude |
| in_q | input | 3 | Q soft decision, sign-magnitude |
| in_act | input | 1 | Signal present for this symbol |
| out_clk | output | 1 | Symbol clock (parallel) or bit clock (serial) |
| out_i | output | 3 | Parallel I lane |
| out_q | output | 3 | Parallel Q lane |
| out_mux | output | 3 | Serial muxed I/Q lane |
| out_sync | output | 1 | Serial slot flag, 1 = I, 0 = Q |
| out_act | output | 1 | Signal activity of the symbol on the output |

## Verification
The hardest situation to reach is a configuration change that lands between the I and Q slots of a QPSK serial symbol. A wrong design would either drop the pending Q word or show it in the new arrangement. The stimulus hands over a QPSK symbol, waits for the out_clk fall that puts its I word on the lane, and checks that in_ready is still low. It then switches to the parallel arrangement and sends the next symbol. The scoreboard expects the Q slot in serial form, followed by a parallel slot. Idle slots are reached by letting the queue drain, and activity pass-through is exercised with symbols whose flag is 0 but whose data is nonzero.

// File: rtl/sdfmt_pkg.sv
package sdfmt_pkg;

    // width of one sign-magnitude soft decision
    localparam int SD_W = 3;

    typedef logic [SD_W-1:0] sd_t;

    typedef struct packed {
        sd_t  i;
        sd_t  q;
        logic act;
    } sym_t;

    // holding-slot sequencer states
    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FULL  = 2'd1,
        ST_QSLOT = 2'd2
    } fmt_state_e;

    // what the output stage loads at a slot start
    typedef enum logic [1:0] {
        SL_NONE = 2'd0,
        SL_PAR  = 2'd1,
        SL_I    = 2'd2,
        SL_Q    = 2'd3
    } slot_e;

endpackage

// File: rtl/sdfmt_clkgen.sv
module sdfmt_clkgen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] half_div,
    output logic             oclk,
    output logic             fall_evt
);

    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap     = (cnt >= half_div);
    // the edge that drops oclk is the edge that starts a new slot
    assign fall_evt = wrap && oclk;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            oclk <= 1'b0;
        end else if (wrap) begin
            cnt  <= '0;
            oclk <= ~oclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sdfmt_seq.sv
module sdfmt_seq
    import sdfmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  slot_evt,
    input  logic  in_valid,
    input  logic  cfg_serial,
    input  logic  cfg_qpsk,
    output logic  in_ready,
    output logic  load,
    output slot_e slot
);

    fmt_state_e state, state_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        in_ready = 1'b0;
        load     = 1'b0;
        slot     = SL_NONE;
        unique case (state)
            ST_EMPTY: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    load     = 1'b1;
                    state_nx = ST_FULL;
                end
            end
            ST_FULL: begin
                if (slot_evt) begin
                    // mode is read here only: the symbol boundary
                    if (!cfg_serial) begin
                        slot     = SL_PAR;
                        state_nx = ST_EMPTY;
                    end else if (!cfg_qpsk) begin
                        slot     = SL_I;
                        state_nx = ST_EMPTY;
                    end else begin
                        slot     = SL_I;
                        state_nx = ST_QSLOT;
                    end
                end
            end
            ST_QSLOT: begin
                if (slot_evt) begin
                    slot     = SL_Q;
                    state_nx = ST_EMPTY;
                end
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

endmodule

// File: rtl/sdfmt_drive.sv
module sdfmt_drive
    import sdfmt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  load,
    input  sym_t  in_sym,
    input  logic  slot_evt,
    input  slot_e slot,
    output sd_t   out_i,
    output sd_t   out_q,
    output sd_t   out_mux,
    output logic  out_sync,
    output logic  out_act
);

    sym_t hold;

    always_ff @(posedge clk) begin
        if (!rst_n) hold <= '0;
        else if (load) hold <= in_sym;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_i    <= '0;
            out_q    <= '0;
            out_mux  <= '0;
            out_sync <= 1'b0;
            out_act  <= 1'b0;
        end else if (slot_evt) begin
            unique case (slot)
                SL_PAR: begin
                    out_i    <= hold.i;
                    out_q    <= hold.q;
                    out_mux  <= '0;
                    out_sync <= 1'b0;
                    out_act  <= hold.act;
                end
                SL_I: begin
                    out_i    <= '0;
                    out_q    <= '0;
                    out_mux  <= hold.i;
                    out_sync <= 1'b1;
                    out_act  <= hold.act;
                end
                SL_Q: begin
                    out_i    <= '0;
                    out_q    <= '0;
                    out_mux  <= hold.q;
                    out_sync <= 1'b0;
                    out_act  <= hold.act;
                end
                default: begin
                    out_i    <= '0;
                    out_q    <= '0;
                    out_mux  <= '0;
                    out_sync <= 1'b0;
                    out_act  <= 1'b0;
                end
            endcase
        end
    end

endmodule

// File: rtl/sdfmt_top.sv
module sdfmt_top
    import sdfmt_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_serial,
    input  logic             cfg_qpsk,
    input  logic [DIV_W-1:0] cfg_half_div,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [SD_W-1:0]  in_i,
    input  logic [SD_W-1:0]  in_q,
    input  logic             in_act,
    output logic             out_clk,
    output logic [SD_W-1:0]  out_i,
    output logic [SD_W-1:0]  out_q,
    output logic [SD_W-1:0]  out_mux,
    output logic             out_sync,
    output logic             out_act
);

    logic  slot_evt;
    logic  load;
    slot_e slot;
    sym_t  in_sym;

    assign in_sym = '{i: in_i, q: in_q, act: in_act};

    sdfmt_clkgen #(.DIV_W(DIV_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .half_div (cfg_half_div),
        .oclk     (out_clk),
        .fall_evt (slot_evt)
    );

    sdfmt_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_evt   (slot_evt),
        .in_valid   (in_valid),
        .cfg_serial (cfg_serial),
        .cfg_qpsk   (cfg_qpsk),
        .in_ready   (in_ready),
        .load       (load),
        .slot       (slot)
    );

    sdfmt_drive u_drive (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .in_sym   (in_sym),
        .slot_evt (slot_evt),
        .slot     (slot),
        .out_i    (out_i),
        .out_q    (out_q),
        .out_mux  (out_mux),
        .out_sync (out_sync),
        .out_act  (out_act)
    );

endmodule

// File: rtl/sdfmt_checker.sv
module sdfmt_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       out_clk,
    input logic       in_valid,
    input logic       in_ready,
    input logic [2:0] out_i,
    input logic [2:0] out_q,
    input logic [2:0] out_mux,
    input logic       out_sync,
    input logic       out_act
);

    // R2: outputs move only together with a falling output clock
    assert_data_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({out_i, out_q, out_mux, out_sync, out_act}) |-> $fell(out_clk));

    // R6: a transfer fills the slot, so ready drops next cycle
    assert_ready_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    // R6: the slot frees only at a slot start
    assert_ready_at_slot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_ready) |-> $fell(out_clk));

    // R3: parallel lanes and serial lane are never active together
    assert_lanes_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ((out_i != 3'd0) || (out_q != 3'd0)) |-> ((out_mux == 3'd0) && !out_sync));

endmodule

bind sdfmt_top sdfmt_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .out_clk  (out_clk),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .out_i    (out_i),
    .out_q    (out_q),
    .out_mux  (out_mux),
    .out_sync (out_sync),
    .out_act  (out_act)
);

// File: tb/sdfmt_top_test.sv
`timescale 1ns/1ps
module sdfmt_top_test;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_serial = 1'b0;
    logic       cfg_qpsk = 1'b0;
    logic [7:0] cfg_half_div = 8'(HALF);
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [2:0] in_i = '0;
    logic [2:0] in_q = '0;
    logic       in_act = 1'b0;
    logic       out_clk;
    logic [2:0] out_i, out_q, out_mux;
    logic       out_sync, out_act;

    int checks = 0;
    int fails  = 0;

    // expected slot: {i, q, mux, sync, act}
    logic [10:0] exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    sdfmt_top uut (
        .clk(clk), .rst_n(rst_n), .cfg_serial(cfg_serial), .cfg_qpsk(cfg_qpsk),
        .cfg_half_div(cfg_half_div), .in_valid(in_valid), .in_ready(in_ready),
        .in_i(in_i), .in_q(in_q), .in_act(in_act), .out_clk(out_clk),
        .out_i(out_i), .out_q(out_q), .out_mux(out_mux), .out_sync(out_sync),
        .out_act(out_act)
    );

    function automatic logic [10:0] mk(logic [2:0] i, logic [2:0] q,
                                       logic [2:0] m, logic s, logic a);
        return {i, q, m, s, a};
    endfunction

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: hand over one symbol and queue what it must produce
    task automatic send(logic [2:0] i, logic [2:0] q, logic a);
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1; in_i = i; in_q = q; in_act = a;
        @(negedge clk);
        in_valid = 1'b0;
        check(in_ready == 1'b0, "R6 ready low after accept", in_ready, 0);
        if (!cfg_serial) exp_q.push_back(mk(i, q, 3'd0, 1'b0, a));
        else begin
            exp_q.push_back(mk(3'd0, 3'd0, i, 1'b1, a));
            if (cfg_qpsk) exp_q.push_back(mk(3'd0, 3'd0, q, 1'b0, a));
        end
    endtask

    // monitor: compare each non-idle slot at the output-clock rise
    initial begin
        forever begin
            @(posedge out_clk);
            #1;
            if ({out_i, out_q, out_mux, out_sync, out_act} != 11'd0) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3/R4/R5 unexpected slot",
                          {out_i, out_q, out_mux, out_sync, out_act}, 0);
                end else begin
                    logic [10:0] e;
                    logic [10:0] got;
                    e   = exp_q.pop_front();
                    got = {out_i, out_q, out_mux, out_sync, out_act};
                    // R7 act bit and R10 word bits are part of the compare
                    if (e[1]) check(got == e, "R4/R5 I slot (R7 R10)", got, e);
                    else if (e[4:2] != 3'd0 || e[10:5] == 6'd0)
                        check(got == e, "R5 Q slot (R7 R10)", got, e);
                    else check(got == e, "R3 parallel slot (R7 R10)", got, e);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

    initial begin
        realtime t0, t1;
        repeat (5) @(negedge clk);
        // R1 reset state
        check(out_clk == 1'b0, "R1 out_clk in reset", out_clk, 0);
        check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
        check({out_i, out_q, out_mux, out_sync, out_act} == 11'd0, "R1 outputs in reset",
              {out_i, out_q, out_mux, out_sync, out_act}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_clk, in_ready, out_i, out_q, out_mux, out_sync, out_act} == 13'h800,
              "R1 state after release",
              {out_clk, in_ready, out_i, out_q, out_mux, out_sync, out_act}, 13'h800);

        // R2 output clock period
        @(posedge out_clk); t0 = $realtime;
        @(posedge out_clk); t1 = $realtime;
        check((t1 - t0) == 2.0 * (HALF + 1) * CLK_PERIOD, "R2 period",
              int'(t1 - t0), 2 * (HALF + 1) * CLK_PERIOD);

        // R3 parallel, R10 word values
        cfg_serial = 1'b0; cfg_qpsk = 1'b1;
        send(3'b100, 3'b011, 1'b1);
        send(3'b111, 3'b000, 1'b1);
        send(3'b001, 3'b110, 1'b1);
        send(3'b010, 3'b101, 1'b1);
        // R7 inactive symbol with data
        send(3'b101, 3'b010, 1'b0);

        // R4 serial BPSK
        @(negedge clk); while (!in_ready) @(negedge clk);
        cfg_serial = 1'b1; cfg_qpsk = 1'b0;
        send(3'b000, 3'b111, 1'b1);
        send(3'b111, 3'b001, 1'b1);
        send(3'b011, 3'b100, 1'b0);
        send(3'b110, 3'b010, 1'b1);

        // R5 serial QPSK
        @(negedge clk); while (!in_ready) @(negedge clk);
        cfg_qpsk = 1'b1;
        send(3'b100, 3'b001, 1'b1);
        send(3'b011, 3'b111, 1'b1);
        send(3'b010, 3'b110, 1'b1);
        send(3'b001, 3'b101, 1'b0);

        // R9: flip mode while Q is pending
        send(3'b110, 3'b011, 1'b1);
        @(negedge out_clk); #1;
        check(out_sync == 1'b1 && out_mux == 3'b110, "R5 I word on lane",
              {out_sync, out_mux}, 4'hE);
        check(in_ready == 1'b0, "R6 ready low while Q pending", in_ready, 0);
        cfg_serial = 1'b0;
        send(3'b101, 3'b100, 1'b1);

        // R8 idle slots after drain
        wait (exp_q.size() == 0);
        @(posedge out_clk); #1;
        @(posedge out_clk); #1;
        check({out_i, out_q, out_mux, out_sync, out_act} == 11'd0, "R8 idle slot",
              {out_i, out_q, out_mux, out_sync, out_act}, 0);
        check(exp_q.size() == 0, "R3/R4/R5 all slots seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule